// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller

This block gathers thirty-two level interrupt inputs from peripherals into one request line for a processor. Each input owns one pending bit in a status register. A rising level sets the bit and a falling level clears it. A processor request is raised while any pending bit is also enabled. Software reaches the block through a small word-addressed register bus. Through that bus it can read the pending bits, clear them by writing ones, overwrite them all with one load, program an enable mask, and read a masked view that shows pending and enabled together.

Peripheral inputs are numbered most-significant-first. The pin for peripheral n feeds status bit 31 − n. Accesses that the register set does not support still complete. They raise a one-cycle error pulse, so that bus logic outside can report them. Such accesses are writes to the masked view, reads of the load register, and any other offset.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the status and enable registers are zero, and cpu_irq_o, bus_err_o and bus_rdata_o are all low.
- R2: A rising edge on a source line sets its status bit at the next clock edge.
- R3: A falling edge on a source line clears its status bit. cpu_irq_o falls only when no bit that is both pending and enabled remains.
- R4: Peripheral input periph_irq_i[n] drives status bit 31 − n, so periph_irq_i[0] appears as status bit 31 (0x8000_0000).
- R5: Offset 0x0 reads the status register. A write there clears each status bit whose written bit is 1.
- R6: A write to offset 0x4 replaces the whole status register with the written value. A read of 0x4 returns the status and also pulses bus_err_o.
- R7: cpu_irq_o equals the OR of (status AND enable), registered. It changes one clock after a source change or a register write, including a write to the enable mask.
- R8: Offset 0x8 is the enable mask and can be read and written.
- R9: A read of offset 0xC returns status AND enable. A write to 0xC changes no state and pulses bus_err_o.
- R10: Any other offset, including offsets not aligned to a word, reads as zero and pulses bus_err_o on a read or a write. A write there changes no state.
- R11: When a source edge and a status write hit the same bit in the same cycle, the source edge decides the bit.
- R12: bus_rdata_o is loaded at the clock edge that samples bus_rd_i and holds between reads. bus_err_o is high for exactly the one cycle after an offending strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| periph_irq_i | input | NUM_SRC | Peripheral level inputs, most-significant-first numbering |
| bus_wr_i | input | 1 | Single-cycle write strobe |
| bus_rd_i | input | 1 | Single-cycle read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Registered read data |
| bus_err_o | output | 1 | One-cycle access-error pulse |
| cpu_irq_o | output | 1 | Registered processor interrupt request |

## Verification
The assertions check on every cycle the behaviours that can be stated locally:
- a source edge sets or clears its own bit;
- the request tracks the enabled pending bits;
- a masked-view write leaves the mask alone;
- an unmapped read returns zero;
- every error pulse follows a strobe.

Some behaviours need a sequence of bus operations, so only the directed scenarios can show them:
- the reversed mapping from peripheral to bit;
- write-one-to-clear;
- the wholesale status load;
- a source edge winning over a same-cycle write;
- read data holding between reads.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    // Register selection produced by the offset decoder
    typedef enum logic [2:0] {
        SEL_STAT = 3'd0,   // pending bits, write-one-to-clear
        SEL_LOAD = 3'd1,   // wholesale status load
        SEL_ENAB = 3'd2,   // enable mask
        SEL_PEND = 3'd3,   // masked view, read only
        SEL_NONE = 3'd4    // unmapped or misaligned
    } reg_sel_e;

    localparam int unsigned NUM_REGS = 4;

endpackage

// File: rtl/irq_line_map.sv
// Reorders peripheral inputs so that peripheral n lands on line N-1-n.
module irq_line_map #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] periph_i,
    output logic [NUM_SRC-1:0] line_o
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rev
        assign line_o[NUM_SRC-1-g] = periph_i[g];
    end

endmodule

// File: rtl/irq_edge_track.sv
// Remembers last sampled levels and reports per-line rising and falling edges.
module irq_edge_track #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] line_i,
    output logic [NUM_SRC-1:0] rise_o,
    output logic [NUM_SRC-1:0] fall_o
);

    logic [NUM_SRC-1:0] level_d, level_q;

    always_comb begin
        level_d = line_i;
        rise_o  = line_i & ~level_q;
        fall_o  = ~line_i & level_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            level_q <= '0;
        end else begin
            level_q <= level_d;
        end
    end

endmodule

// File: rtl/irq_addr_dec.sv
// Maps a byte offset to a register selection; misaligned or out-of-range is SEL_NONE.
module irq_addr_dec
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = addr_i[ADDR_W-1:2];
        sel_o = SEL_NONE;
        if (addr_i[1:0] == 2'b00) begin
            if (idx == IDX_W'(0))      sel_o = SEL_STAT;
            else if (idx == IDX_W'(1)) sel_o = SEL_LOAD;
            else if (idx == IDX_W'(2)) sel_o = SEL_ENAB;
            else if (idx == IDX_W'(3)) sel_o = SEL_PEND;
        end
    end

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] periph_irq_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               bus_err_o,
    output logic               cpu_irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] rdata;
        logic               irq;
        logic               err;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0] line;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;
    reg_sel_e           sel;

    // Exposed for the bound checker
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;

    irq_line_map #(.NUM_SRC(NUM_SRC)) u_map (
        .periph_i (periph_irq_i),
        .line_o   (line)
    );

    irq_edge_track #(.NUM_SRC(NUM_SRC)) u_track (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (line),
        .rise_o (rise),
        .fall_o (fall)
    );

    irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    logic [NUM_SRC-1:0] base_status;
    logic [NUM_SRC-1:0] rd_val;
    logic               bad_wr;
    logic               bad_rd;

    always_comb begin
        st_d        = st_q;
        base_status = st_q.status;
        rd_val      = '0;
        bad_wr      = 1'b0;
        bad_rd      = 1'b0;

        if (bus_wr_i) begin
            unique case (sel)
                SEL_STAT: base_status = st_q.status & ~bus_wdata_i;
                SEL_LOAD: base_status = bus_wdata_i;
                SEL_ENAB: st_d.enable = bus_wdata_i;
                SEL_PEND: bad_wr      = 1'b1;
                default:  bad_wr      = 1'b1;
            endcase
        end

        if (bus_rd_i) begin
            unique case (sel)
                SEL_STAT: rd_val = st_q.status;
                SEL_LOAD: begin
                    rd_val = st_q.status;
                    bad_rd = 1'b1;
                end
                SEL_ENAB: rd_val = st_q.enable;
                SEL_PEND: rd_val = st_q.status & st_q.enable;
                default: begin
                    rd_val = '0;
                    bad_rd = 1'b1;
                end
            endcase
        end

        // Source edges take precedence over the bus for the bits they touch
        st_d.status = (base_status | rise) & ~fall;
        st_d.irq    = |(st_d.status & st_d.enable);
        st_d.rdata  = bus_rd_i ? rd_val : st_q.rdata;
        st_d.err    = bad_wr | bad_rd;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q    = st_q.status;
    assign enable_q    = st_q.enable;
    assign bus_rdata_o = st_q.rdata;
    assign bus_err_o   = st_q.err;
    assign cpu_irq_o   = st_q.irq;

endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [NUM_SRC-1:0] bus_rdata_o,
    input logic               bus_err_o,
    input logic               cpu_irq_o,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [NUM_SRC-1:0] rise,
    input logic [NUM_SRC-1:0] fall
);

    logic unmapped;
    assign unmapped = (bus_addr_i[1:0] != 2'b00) || ((bus_addr_i >> 2) > ADDR_W'(3));

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (status_q == '0 && enable_q == '0 && !cpu_irq_o && !bus_err_o));

    a_r2_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise != '0) |=> ((status_q & $past(rise)) == $past(rise)));

    a_r3_fall_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall != '0) |=> ((status_q & $past(fall)) == '0));

    a_r7_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_irq_o == (|(status_q & enable_q)));

    a_r9_pend_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_W'(12)) |=> ($stable(enable_q) && bus_err_o));

    a_r10_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && unmapped) |=> (bus_rdata_o == '0 && bus_err_o));

    a_r12_err_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> $past(bus_rd_i || bus_wr_i));

endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .bus_err_o   (bus_err_o),
    .cpu_irq_o   (cpu_irq_o),
    .status_q    (status_q),
    .enable_q    (enable_q),
    .rise        (rise),
    .fall        (fall)
);

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;

    localparam int unsigned N      = 32;
    localparam int unsigned AW     = 4;
    localparam time         CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  periph = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          err;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    irq_level_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .periph_irq_i (periph),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .bus_err_o    (err),
        .cpu_irq_o    (irq)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(logic [AW-1:0] a, logic [N-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [N-1:0] d, output logic e);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata; e = err;
    endtask

    task automatic set_periph(logic [N-1:0] v);
        periph = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] d; logic e;
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 err", {31'b0, err}, 0);
        check("R1 rdata", rdata, 0);
        bus_read(4'h0, d, e); check("R1 status", d, 0);
        bus_read(4'h8, d, e); check("R1 enable", d, 0);
    endtask

    task automatic t_map_and_rise();
        logic [N-1:0] d; logic e;
        set_periph(32'h0000_0001);
        check("R2 irq masked", {31'b0, irq}, 0);
        bus_read(4'h0, d, e);
        check("R4 R2 periph0 to bit31", d, 32'h8000_0000);
        check("R5 status read no err", {31'b0, e}, 0);
        set_periph(32'h0000_0003);
        bus_read(4'h0, d, e);
        check("R4 periph1 to bit30", d, 32'hC000_0000);
    endtask

    task automatic t_enable_and_fall();
        logic [N-1:0] d; logic e;
        bus_write(4'h8, 32'h8000_0000);
        check("R7 irq after enable write", {31'b0, irq}, 1);
        bus_read(4'h8, d, e);
        check("R8 enable readback", d, 32'h8000_0000);
        set_periph(32'h0000_0001);           // periph1 falls, bit30 not enabled
        check("R3 irq stays with enabled pending", {31'b0, irq}, 1);
        bus_read(4'h0, d, e);
        check("R3 bit30 cleared", d, 32'h8000_0000);
        set_periph(32'h0000_0000);
        check("R3 irq drops", {31'b0, irq}, 0);
        bus_read(4'h0, d, e);
        check("R3 status empty", d, 0);
    endtask

    task automatic t_w1c();
        logic [N-1:0] d; logic e;
        set_periph(32'h0000_0005);           // bits 31 and 29
        bus_write(4'h0, 32'h2000_0000);
        bus_read(4'h0, d, e);
        check("R5 write-one-to-clear", d, 32'h8000_0000);
        bus_write(4'h0, 32'h8000_0000);
        check("R7 irq after clear", {31'b0, irq}, 0);
        bus_read(4'h0, d, e);
        check("R5 level held, bit stays clear", d, 0);
        set_periph(32'h0000_0000);
    endtask

    task automatic t_load();
        logic [N-1:0] d; logic e;
        bus_write(4'h4, 32'h0000_00F0);
        check("R6 load no err", {31'b0, err}, 0);
        bus_read(4'h0, d, e);
        check("R6 status replaced", d, 32'h0000_00F0);
        bus_read(4'h4, d, e);
        check("R6 load read value", d, 32'h0000_00F0);
        check("R6 load read err", {31'b0, e}, 1);
    endtask

    task automatic t_masked();
        logic [N-1:0] d; logic e;
        bus_write(4'h8, 32'h0000_0030);
        check("R7 irq after enable", {31'b0, irq}, 1);
        bus_read(4'hC, d, e);
        check("R9 masked read", d, 32'h0000_0030);
        check("R9 masked read no err", {31'b0, e}, 0);
        bus_write(4'hC, 32'hFFFF_FFFF);
        check("R9 masked write err", {31'b0, err}, 1);
        @(negedge clk);
        check("R12 err single cycle", {31'b0, err}, 0);
        bus_read(4'h8, d, e);
        check("R9 enable unchanged", d, 32'h0000_0030);
        bus_read(4'h0, d, e);
        check("R9 status unchanged", d, 32'h0000_00F0);
    endtask

    task automatic t_unmapped();
        logic [N-1:0] d; logic e;
        bus_read(4'h1, d, e);
        check("R10 misaligned read zero", d, 0);
        check("R10 misaligned read err", {31'b0, e}, 1);
        bus_read(4'hD, d, e);
        check("R10 odd read err", {31'b0, e}, 1);
        bus_write(4'h6, 32'hFFFF_FFFF);
        check("R10 write err", {31'b0, err}, 1);
        bus_read(4'h0, d, e);
        check("R10 status untouched", d, 32'h0000_00F0);
        bus_read(4'h8, d, e);
        check("R10 enable untouched", d, 32'h0000_0030);
    endtask

    task automatic t_hold();
        logic [N-1:0] d; logic e;
        bus_read(4'h8, d, e);
        repeat (3) @(negedge clk);
        check("R12 rdata held", rdata, 32'h0000_0030);
        check("R12 no err idle", {31'b0, err}, 0);
    endtask

    task automatic t_conflict();
        logic [N-1:0] d; logic e;
        bus_write(4'h8, 32'h0000_0000);
        periph = 32'h0000_0001;              // rises with a zero load
        bus_write(4'h4, 32'h0000_0000);
        bus_read(4'h0, d, e);
        check("R11 rise beats load", d, 32'h8000_0000);
        periph = 32'h0000_0000;              // falls with a set-all load
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_read(4'h0, d, e);
        check("R11 fall beats load", d, 32'h7FFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_and_rise();
        t_enable_and_fall();
        t_w1c();
        t_load();
        t_masked();
        t_unmapped();
        t_hold();
        t_conflict();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule